// File: doc/BRIEF.md
# Ternary Weight Dot-Product Engine

This block computes the dot product of a ternary weight vector and a signed 8-bit activation vector. No multiplier is used anywhere in the datapath. Each weight is a 2-bit code standing for -1, 0 or +1. A vector arrives as a stream of beats, and every beat carries a fixed number of lanes of weight codes and activations. The input stream is valid/ready, and each beat is marked as the first of a vector, the last of a vector, or both.

The lanes are taken two at a time. For each pair, the nine possible signed combinations of the two activations (zero, the single values with either sign, and the sums and differences) are formed ahead of the weights. The two decoded weight codes then index that small table. The pair results of a beat are added into a 24-bit signed accumulator. The accumulator restarts from zero on a beat flagged first. One cycle after the beat flagged last is accepted, the total appears on a registered output with a valid flag. That output stays put until the consumer takes it.

Top module: `ternary_dot`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each 2-bit weight code of lane i occupies in_wcode bits [2i+1:2i] and applies to activation in_act bits [8i+7:8i]. Code 2'b01 means +1, code 2'b11 means -1, and codes 2'b00 and 2'b10 both mean 0.
- R3: For a vector of a single beat, out_sum equals the sum over all lanes of weight times activation, with activations taken as two's-complement signed values.
- R4: For a vector of several beats, out_sum equals the sum over all beats of their lane products. A beat flagged first discards any earlier partial sum.
- R5: out_valid becomes 1 on the clock edge after the edge that accepts the beat flagged last, and never before that beat.
- R6: While out_valid is 1 and out_ready is 0, out_valid and out_sum stay unchanged and in_ready is 0. out_valid returns to 0 on the edge where out_ready is 1, unless a new last beat is accepted on that same edge.
- R7: Cycles with in_valid at 0 leave the accumulation unchanged, whatever in_wcode, in_act and the flags hold.
- R8: A beat flagged both first and last produces a result that holds only that beat's sum.
- R9: Extreme activations are summed exactly. With 8 lanes of -128, every weight at -1 gives +1024 and every weight at +1 gives -1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_first | input | 1 | Beat starts a new vector |
| in_last | input | 1 | Beat ends the vector |
| in_wcode | input | 2*LANES | Packed ternary weight codes, lane 0 in the low bits |
| in_act | input | 8*LANES | Packed signed activations, lane 0 in the low bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | ACCW | Signed dot-product result |

## Verification
The bench uses the default parameters: 8 lanes, which make four lookup pairs, 8-bit activations and a 24-bit accumulator. With 8 lanes, a beat of all -128 activations reaches the full ±1024 range of a beat. Every pair position and both halves of a pair are covered by the per-lane decode tests. Stalled outputs, idle cycles carrying garbage between beats, and back-to-back vectors exercise the handshake around the registered result.

// File: rtl/ternary_dot.sv
module ternary_dot #(
  parameter int LANES = 8,
  parameter int AW    = 8,
  parameter int ACCW  = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_first,
  input  logic                  in_last,
  input  logic [2*LANES-1:0]    in_wcode,
  input  logic [AW*LANES-1:0]   in_act,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ACCW-1:0]       out_sum
);
  localparam int PAIRS = LANES / 2;
  localparam int PW    = AW + 2;
  localparam int BW    = AW + 1 + $clog2(LANES);

  logic signed [PW-1:0]   pair_sum [PAIRS];
  logic signed [BW-1:0]   beat_sum;
  logic signed [ACCW-1:0] acc, acc_base, acc_next;
  logic                   take;

  function automatic logic [1:0] dec(input logic [1:0] c);
    case (c)
      2'b01:   dec = 2'd1;
      2'b11:   dec = 2'd2;
      default: dec = 2'd0;
    endcase
  endfunction

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    logic signed [AW-1:0] a0, a1;
    logic signed [PW-1:0] e0, e1;
    logic signed [PW-1:0] tbl [16];
    logic [3:0]           idx;

    assign a0  = in_act[(2*g)*AW +: AW];
    assign a1  = in_act[(2*g+1)*AW +: AW];
    assign e0  = PW'(a0);
    assign e1  = PW'(a1);
    assign idx = {dec(in_wcode[4*g+2 +: 2]), dec(in_wcode[4*g +: 2])};

    always_comb begin
      for (int k = 0; k < 16; k++) tbl[k] = '0;
      tbl[4'h1] = e0;
      tbl[4'h2] = -e0;
      tbl[4'h4] = e1;
      tbl[4'h5] = e1 + e0;
      tbl[4'h6] = e1 - e0;
      tbl[4'h8] = -e1;
      tbl[4'h9] = e0 - e1;
      tbl[4'hA] = -e1 - e0;
    end

    assign pair_sum[g] = tbl[idx];
  end

  always_comb begin
    beat_sum = '0;
    for (int p = 0; p < PAIRS; p++) beat_sum = beat_sum + BW'(pair_sum[p]);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign acc_base = in_first ? '0 : acc;
  assign acc_next = acc_base + ACCW'(beat_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        acc <= acc_next;
        if (in_last) begin
          out_sum   <= acc_next;
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ternary_dot_chk.sv
module ternary_dot_chk #(
  parameter int ACCW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_last,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ACCW-1:0] out_sum
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum)); // R6
  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> out_valid); // R5
  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_last)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !out_valid |=> !out_valid); // R7
  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R6
endmodule

bind ternary_dot ternary_dot_chk #(.ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_sum(out_sum)
);

// File: tb/sim_ternary_dot.sv
`timescale 1ns/1ps
module sim_ternary_dot;
  localparam int LANES = 8;
  localparam int AW    = 8;
  localparam int ACCW  = 24;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, out_ready = 0;
  logic [2*LANES-1:0]  in_wcode = '0;
  logic [AW*LANES-1:0] in_act = '0;
  logic in_ready, out_valid;
  logic [ACCW-1:0] out_sum;

  int checks = 0, fails = 0;
  logic [1:0]        wc [LANES];
  logic signed [7:0] ac [LANES];
  int expv;

  always #5 clk = ~clk;

  ternary_dot #(.LANES(LANES), .AW(AW), .ACCW(ACCW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_wcode(in_wcode), .in_act(in_act),
    .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wval(logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  function automatic int model();
    int s = 0;
    for (int i = 0; i < LANES; i++) s += wval(wc[i]) * int'(ac[i]);
    return s;
  endfunction

  task automatic rnd_beat();
    for (int i = 0; i < LANES; i++) begin
      wc[i] = 2'($urandom);
      ac[i] = 8'($urandom);
    end
  endtask

  task automatic beat(logic f, logic l);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) begin
      in_wcode[2*i +: 2] = wc[i];
      in_act[8*i +: 8]   = ac[i];
    end
    in_first = f; in_last = l; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    in_wcode = 16'hFFFF; in_act = '1;
  endtask

  task automatic collect(string req, int exp);
    chk("R5", out_valid, 1);
    chk(req, $signed(out_sum), exp);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    chk("R6", out_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1", out_valid, 0);
    chk("R1", in_ready, 1);
  endtask

  task automatic t_decode();
    logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    int wv [4] = '{0, 1, -1, 0};
    for (int ln = 0; ln < LANES; ln++)
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < LANES; i++) begin wc[i] = 2'b00; ac[i] = 8'sd99; end
        wc[ln] = codes[k]; ac[ln] = 8'sd37 + 8'(ln);
        beat(1, 1);
        collect("R2", wv[k] * (37 + ln));
      end
  endtask

  task automatic t_single();
    for (int n = 0; n < 20; n++) begin
      rnd_beat();
      expv = model();
      beat(1, 1);
      collect("R3", expv);
    end
  endtask

  task automatic t_multi();
    for (int v = 0; v < 6; v++) begin
      int nb = 2 + v;
      expv = 0;
      for (int b = 0; b < nb; b++) begin
        rnd_beat();
        expv += model();
        beat(b == 0, b == nb - 1);
        if (b != nb - 1) chk("R5", out_valid, 0);
      end
      collect("R4", expv);
    end
    rnd_beat(); beat(1, 0);
    rnd_beat(); expv = model(); beat(1, 1);
    collect("R4", expv);
  endtask

  task automatic t_single_after_partial();
    rnd_beat(); beat(1, 0);
    rnd_beat(); beat(0, 0);
    for (int i = 0; i < LANES; i++) begin wc[i] = 2'b01; ac[i] = 8'sd5; end
    beat(1, 1);
    collect("R8", 40);
  endtask

  task automatic t_gap();
    expv = 0;
    rnd_beat(); expv += model(); beat(1, 0);
    @(negedge clk);
    in_first = 1; in_last = 1; in_wcode = 16'h5555; in_act = '1;
    repeat (4) @(negedge clk);
    chk("R7", out_valid, 0);
    in_first = 0; in_last = 0;
    rnd_beat(); expv += model(); beat(0, 1);
    collect("R7", expv);
  endtask

  task automatic t_hold();
    rnd_beat(); expv = model(); beat(1, 1);
    for (int c = 0; c < 5; c++) begin
      chk("R6", out_valid, 1);
      chk("R6", $signed(out_sum), expv);
      chk("R6", in_ready, 0);
      @(negedge clk);
    end
    collect("R6", expv);
  endtask

  task automatic t_extreme();
    for (int i = 0; i < LANES; i++) begin wc[i] = 2'b11; ac[i] = -8'sd128; end
    beat(1, 1); collect("R9", 1024);
    for (int i = 0; i < LANES; i++) wc[i] = 2'b01;
    beat(1, 1); collect("R9", -1024);
    for (int b = 0; b < 4; b++) beat(b == 0, b == 3);
    collect("R9", -4096);
    for (int i = 0; i < LANES; i++) begin wc[i] = 2'b01; ac[i] = 8'sd127; end
    beat(1, 1); collect("R9", 1016);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_single();
    t_multi();
    t_single_after_partial();
    t_gap();
    t_hold();
    t_extreme();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule